// File: doc/BRIEF.md
# MDIO Status Auto-Poll Engine

This block watches an external Ethernet PHY without software help. While polling is enabled it generates the MII management clock (MDC) from the system clock and issues clause-22 read frames for status register 1 at a configured PHY address. It captures the 16-bit reply and holds it on a status output. Between frames it idles for a coded number of MDC periods, or starts the next frame at once in continuous mode.

The first reply after polling is enabled becomes the reference value. After that, any reply that differs from the held word replaces it and, when the interrupt enable is set, sets a sticky flag. Software clears the flag by writing a one to it.

A single 8-bit write port loads the configuration. Bit 0 is the poll enable, bit 1 the interrupt enable, bits 3:2 the MDC rate code and bits 6:4 the dwell code. Bit 7 is write-one-to-clear for the flag. A soft reset restarts the engine but leaves the configuration as it is.

The sequencer has six states:
- IDLE: MDC is held low and MDIO is released.
- PREAMBLE: 32 ones.
- HEADER: 14 bits of start, opcode, PHY address and register address.
- TURN: 2 released bits.
- DATA: 16 sampled bits.
- DWELL: the released gap between frames.

The transitions are:
- IDLE to PREAMBLE when enabled.
- PREAMBLE to HEADER after bit 32.
- HEADER to TURN after bit 14.
- TURN to DATA after bit 2.
- DATA to DWELL after bit 16, or DATA to PREAMBLE when the dwell code is 000.
- DWELL to PREAMBLE after N MDC periods.
- Any state to IDLE when the enable drops or on soft reset.

Top module: `mdio_autopoll`

## Requirements
- R1: The MDC period is 2×HALF_SLOW system clocks for rate code 00, 2×HALF_MID for 01 and 2×HALF_FAST for 10. The reserved code 11 uses the slow rate. With the defaults and a 125 MHz clock these periods are 400 ns, 208 ns and 112 ns.
- R2: Frames are issued only while config bit 0 is 1. One cycle after the enable reads 0, MDC is low and MDIO is released, and no further frames complete.
- R3: Each frame drives, MSB first, 32 ones, then 01, then 10, then the 5-bit PHY address, then register address 00001. Driven bits change only after an MDC falling edge. MDIO is then released for 2 turnaround and 16 data bit times.
- R4: The 16 data bits are sampled on MDC rising edges, MSB first. At the end of the frame they appear on `status`.
- R5: The number of MDC rising edges from MDIO release to the next frame's first driven bit is 18+N. N is 0, 128, 256, 512, 1024 or 2048 for dwell codes 000 to 101, and 2048 for the reserved codes 110 and 111.
- R6: A reply that differs from `status` updates it and sets `irq` when config bit 1 is 1. A reply equal to `status` does not set `irq`. With config bit 1 at 0, a differing reply updates `status` and leaves `irq` at 0.
- R7: The first reply after enabling only loads `status` and raises `status_valid`. It never sets `irq`.
- R8: Once set, `irq` stays 1 until a write with bit 7 set or a soft reset. A write with bit 7 at 0 leaves it set.
- R9: After hard reset the configuration reads 7'h40 (dwell 100, rate 00, both enables 0), and MDC, MDIO enable, `irq` and `status_valid` are 0.
- R10: A soft reset keeps the configuration and clears `irq`, `status_valid` and MDC on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset |
| soft_rst | input | 1 | Synchronous engine restart that keeps the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Write data: [0] enable, [1] irq enable, [3:2] rate, [6:4] dwell, [7] flag clear |
| phy_addr | input | 5 | PHY address placed in the frame |
| cfg_q | output | 7 | Current configuration fields |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO pin input |
| status | output | 16 | Last captured PHY status word |
| status_valid | output | 1 | A reference status has been loaded |
| irq | output | 1 | Sticky status-change flag |

## Verification
The assertions check several rules on every cycle:
- A cleared enable silences MDC and MDIO by the next cycle.
- The flag holds until cleared.
- A rising flag always comes with a changed status word that already had a reference.
- The reference load never raises the flag.
- Soft reset clears the engine state.

Other behaviour can only be shown by the bench's scenarios, using a PHY stub. These are the exact bit pattern of a frame, the MDC period for each rate code, the dwell gap counted in MDC edges for each dwell code, and the data sampling order.

// File: rtl/mdio_autopoll_pkg.sv
package mdio_autopoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_DWELL
    } poll_state_t;

    localparam int PREAMBLE_BITS = 32;
    localparam int HEADER_BITS   = 14;
    localparam int TURN_BITS     = 2;
    localparam int DATA_BITS     = 16;
    localparam int ADDR_BITS     = 5;
    localparam logic [ADDR_BITS-1:0] STATUS_REG = 5'd1;

    // Packed so the first member is the most significant field.
    typedef struct packed {
        logic [2:0] dwell;
        logic [1:0] rate;
        logic       irq_en;
        logic       poll_en;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);

    localparam cfg_t CFG_RESET = '{dwell: 3'b100, rate: 2'b00, irq_en: 1'b0, poll_en: 1'b0};

    // Gap length in MDC periods for a dwell code; codes past 101 saturate.
    function automatic int unsigned dwell_periods(input logic [2:0] code, input int unsigned base);
        if (code == 3'd0)
            return 0;
        else if (code >= 3'd5)
            return base << 4;
        else
            return base << (int'(code) - 1);
    endfunction

endpackage

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs
    import mdio_autopoll_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                we,
    input  logic [CFG_BITS:0]   wdata,
    input  logic                irq_set,
    output cfg_t                cfg,
    output logic                irq
);

    localparam int CLR_BIT = CFG_BITS;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= CFG_RESET;
        else if (we)
            cfg <= cfg_t'(wdata[CFG_BITS-1:0]);
    end

    // Set wins over a same-cycle clear so no change event is lost.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            irq <= 1'b0;
        else if (irq_set)
            irq <= 1'b1;
        else if (we && wdata[CLR_BIT])
            irq <= 1'b0;
    end

endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_SLOW = 25,
    parameter int HALF_MID  = 13,
    parameter int HALF_FAST = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);

    localparam int HMAX = (HALF_SLOW > HALF_MID) ?
                          ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST) :
                          ((HALF_MID  > HALF_FAST) ? HALF_MID  : HALF_FAST);
    localparam int CW = $clog2(HMAX + 1);

    logic [CW-1:0] half;
    logic [CW-1:0] cnt;
    logic          wrap;

    always_comb begin
        unique case (rate)
            2'b01:   half = CW'(HALF_MID);
            2'b10:   half = CW'(HALF_FAST);
            default: half = CW'(HALF_SLOW);
        endcase
    end

    // >= keeps the divider safe if the rate code changes mid half-period.
    assign wrap = run && (cnt >= half - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_poll_fsm.sv
module mdio_poll_fsm
    import mdio_autopoll_pkg::*;
#(
    parameter int DWELL_BASE = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 poll_en,
    input  logic                 irq_en,
    input  logic [2:0]           dwell,
    input  logic [ADDR_BITS-1:0] phy_addr,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [DATA_BITS-1:0] status,
    output logic                 status_valid,
    output logic                 irq_set
);

    localparam int DW = $clog2(DWELL_BASE * 16) + 1;
    localparam int HW = $clog2(HEADER_BITS);

    poll_state_t          state, nxt;
    logic [DW-1:0]        cnt;
    logic [DW-1:0]        limit;
    logic [DW-1:0]        gap_len;
    logic                 last_bit;
    logic                 done;
    logic [DATA_BITS-1:0] shreg;
    logic [HEADER_BITS-1:0] header;
    logic [HW-1:0]        hidx;

    assign header  = {2'b01, 2'b10, phy_addr, STATUS_REG};
    assign gap_len = DW'(dwell_periods(dwell, DWELL_BASE));
    assign hidx    = HW'(HEADER_BITS - 1) - cnt[HW-1:0];

    always_comb begin
        unique case (state)
            ST_PREAMBLE: limit = DW'(PREAMBLE_BITS);
            ST_HEADER:   limit = DW'(HEADER_BITS);
            ST_TURN:     limit = DW'(TURN_BITS);
            ST_DATA:     limit = DW'(DATA_BITS);
            ST_DWELL:    limit = gap_len;
            default:     limit = DW'(1);
        endcase
    end

    assign last_bit = fall && (cnt >= limit - 1'b1);
    assign done     = poll_en && (state == ST_DATA) && last_bit;

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (poll_en)  nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (last_bit) nxt = ST_HEADER;
            ST_HEADER:   if (last_bit) nxt = ST_TURN;
            ST_TURN:     if (last_bit) nxt = ST_DATA;
            ST_DATA:     if (last_bit) nxt = (gap_len == '0) ? ST_PREAMBLE : ST_DWELL;
            ST_DWELL:    if (last_bit) nxt = ST_PREAMBLE;
            default:     nxt = ST_IDLE;
        endcase
        if (!poll_en)
            nxt = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Bit counter and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cnt   <= '0;
            shreg <= '0;
        end else begin
            if (state != nxt)
                cnt <= '0;
            else if (fall)
                cnt <= cnt + 1'b1;
            if (state == ST_DATA && rise)
                shreg <= {shreg[DATA_BITS-2:0], mdio_i};
        end
    end

    // Reference status and compare.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status       <= '0;
            status_valid <= 1'b0;
        end else if (!poll_en) begin
            status_valid <= 1'b0;
        end else if (done) begin
            status       <= shreg;
            status_valid <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        mdio_oe = 1'b0;
        mdio_o  = 1'b0;
        irq_set = done && status_valid && irq_en && (shreg != status);
        unique case (state)
            ST_PREAMBLE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_HEADER: begin
                mdio_oe = 1'b1;
                mdio_o  = header[hidx];
            end
            default: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mdio_autopoll.sv
module mdio_autopoll
    import mdio_autopoll_pkg::*;
#(
    parameter int HALF_SLOW  = 25,
    parameter int HALF_MID   = 13,
    parameter int HALF_FAST  = 7,
    parameter int DWELL_BASE = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    input  logic [4:0]  phy_addr,
    output logic [6:0]  cfg_q,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic [15:0] status,
    output logic        status_valid,
    output logic        irq
);

    cfg_t cfg;
    logic mdc_rise;
    logic mdc_fall;
    logic irq_set;

    assign cfg_q = cfg;

    mdio_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .irq_set  (irq_set),
        .cfg      (cfg),
        .irq      (irq)
    );

    mdio_mdc_gen #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_MID  (HALF_MID),
        .HALF_FAST (HALF_FAST)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run      (cfg.poll_en),
        .rate     (cfg.rate),
        .mdc      (mdc),
        .rise     (mdc_rise),
        .fall     (mdc_fall)
    );

    mdio_poll_fsm #(
        .DWELL_BASE (DWELL_BASE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .poll_en      (cfg.poll_en),
        .irq_en       (cfg.irq_en),
        .dwell        (cfg.dwell),
        .phy_addr     (phy_addr),
        .rise         (mdc_rise),
        .fall         (mdc_fall),
        .mdio_i       (mdio_i),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .status       (status),
        .status_valid (status_valid),
        .irq_set      (irq_set)
    );

endmodule

// File: rtl/mdio_autopoll_chk.sv
module mdio_autopoll_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        clr_wr,
    input logic        poll_en,
    input logic        mdc,
    input logic        mdio_oe,
    input logic [15:0] status,
    input logic        status_valid,
    input logic        irq
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_en |=> (!mdio_oe && !mdc)); // R2

    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((status != $past(status)) && $past(status_valid))); // R6

    AST_FIRST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_valid) |-> !$rose(irq)); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !soft_rst && !clr_wr) |=> irq); // R8

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!mdc && !status_valid && !irq)); // R10

endmodule

bind mdio_autopoll mdio_autopoll_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .clr_wr       (cfg_we && cfg_wdata[7]),
    .poll_en      (cfg_q[0]),
    .mdc          (mdc),
    .mdio_oe      (mdio_oe),
    .status       (status),
    .status_valid (status_valid),
    .irq          (irq)
);

// File: tb/mdio_autopoll_test.sv
`timescale 1ns/1ps
module mdio_autopoll_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [4:0]  phy_addr = 5'h13;
    logic [6:0]  cfg_q;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;
    logic [15:0] status;
    logic        status_valid;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    mdio_autopoll uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .phy_addr(phy_addr), .cfg_q(cfg_q), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .status(status),
        .status_valid(status_valid), .irq(irq)
    );

    // PHY stub and monitors
    logic [15:0] phy_status = 16'h0000;
    logic [45:0] sh46 = '0;
    logic [45:0] last_hdr = '0;
    int tacnt = 100;
    int frames = 0;
    int rises = 0;

    always @(posedge mdc) begin
        rises++;
        if (mdio_oe) sh46 = {sh46[44:0], mdio_o};
    end

    always @(negedge mdio_oe) last_hdr = sh46;

    always begin
        @(negedge mdc);
        #1;
        if (tacnt == 18) frames++;
        if (mdio_oe) tacnt = 0;
        else if (tacnt < 100) tacnt++;
        mdio_i = (tacnt >= 3 && tacnt <= 18) ? phy_status[18 - tacnt] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input bit en, input bit ie, input logic [1:0] rate, input logic [2:0] dw);
        return {1'b0, dw, rate, ie, en};
    endfunction

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target = frames + n;
        wait (frames >= target);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(cfg_q == 7'h40, "R9 cfg", cfg_q, 7'h40);
        check({mdc, mdio_oe, irq, status_valid} == 4'b0, "R9 outputs", {mdc, mdio_oe, irq, status_valid}, 0);
    endtask

    task automatic t_rates();
        int exp_ns[4] = '{400, 208, 112, 400};
        for (int s = 0; s < 4; s++) begin
            realtime t0, t1;
            write_cfg(mk(0, 0, 2'b00, 3'd0));
            write_cfg(mk(1, 0, s[1:0], 3'd0));
            @(posedge mdc); t0 = $realtime;
            @(posedge mdc); t1 = $realtime;
            check(int'(t1 - t0) == exp_ns[s], "R1 mdc period", int'(t1 - t0), exp_ns[s]);
        end
        write_cfg(mk(0, 0, 2'b00, 3'd0));
    endtask

    task automatic t_first_frame();
        phy_status = 16'hA5C3;
        write_cfg(mk(1, 1, 2'b10, 3'd0));
        wait_frames(1);
        check(last_hdr == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h13, 5'b00001}, "R3 frame bits", last_hdr,
              {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h13, 5'b00001});
        check(status == 16'hA5C3, "R4 status capture", status, 16'hA5C3);
        check(status_valid && !irq, "R7 first load", {status_valid, irq}, 2'b10);
    endtask

    task automatic t_change_irq();
        phy_status = 16'h1234;
        wait_frames(2);
        check(status == 16'h1234 && irq, "R6 change raises irq", {irq, status}, {1'b1, 16'h1234});
        write_cfg(mk(1, 1, 2'b10, 3'd0) | 8'h80);
        check(!irq, "R8 w1c clear", irq, 0);
        wait_frames(2);
        check(!irq, "R6 same value no irq", irq, 0);
        phy_status = 16'h0F0F;
        wait_frames(2);
        write_cfg(mk(1, 1, 2'b10, 3'd0));
        wait_frames(1);
        check(irq, "R8 sticky without clear bit", irq, 1);
        write_cfg(mk(1, 1, 2'b10, 3'd0) | 8'h80);
    endtask

    task automatic t_irq_disabled();
        write_cfg(mk(1, 0, 2'b10, 3'd0));
        phy_status = 16'hBEEF;
        wait_frames(2);
        check(status == 16'hBEEF && !irq, "R6 irq disabled", {irq, status}, {1'b0, 16'hBEEF});
    endtask

    task automatic t_disable();
        int f0;
        write_cfg(mk(0, 0, 2'b10, 3'd0));
        @(negedge clk);
        check(!mdc && !mdio_oe, "R2 quiet when off", {mdc, mdio_oe}, 0);
        f0 = frames;
        repeat (2000) @(negedge clk);
        check(frames == f0 && !mdc, "R2 no frames when off", frames, f0);
    endtask

    task automatic t_reenable();
        phy_status = 16'h7777;
        write_cfg(mk(1, 1, 2'b10, 3'd0));
        wait_frames(1);
        check(status == 16'h7777 && !irq, "R7 reload after enable", {irq, status}, {1'b0, 16'h7777});
    endtask

    task automatic t_dwell();
        logic [2:0] codes[4] = '{3'd0, 3'd1, 3'd3, 3'd7};
        int exp_gap[4] = '{18, 146, 530, 2066};
        for (int k = 0; k < 4; k++) begin
            int r0;
            write_cfg(mk(0, 0, 2'b10, 3'd0));
            write_cfg(mk(1, 0, 2'b10, codes[k]));
            @(negedge mdio_oe); r0 = rises;
            @(posedge mdio_oe);
            check(rises - r0 == exp_gap[k], "R5 dwell gap", rises - r0, exp_gap[k]);
        end
    endtask

    task automatic t_soft_reset();
        write_cfg(mk(0, 0, 2'b10, 3'd0));
        write_cfg(mk(1, 1, 2'b10, 3'd0));
        wait_frames(1);
        phy_status = 16'h4242;
        wait_frames(2);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(cfg_q == 7'h0B, "R10 cfg kept", cfg_q, 7'h0B);
        check(!irq && !status_valid, "R10 engine cleared", {irq, status_valid}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            tests++;
            fails++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rates();
        t_first_frame();
        t_change_irq();
        t_irq_disabled();
        t_disable();
        t_reenable();
        t_dwell();
        t_soft_reset();
        ended = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule